// File: doc/BRIEF.md
# Clock Output Gating Controller

This block is the digital control layer that sits between the clock synthesis core of a multi-output clock generator and its output pads. It takes clock phases that are already generated (CPU, PCI, reference, 48 MHz, 24 MHz) and the buffered SDRAM input. It decides, cycle by cycle, which of them reach the pads. All decisions are sampled on a fast control clock `clk`. The phase inputs are treated as slow data waveforms relative to it.

Several output pads double as configuration straps. While reset is held, their drivers stay off. On the first control clock after reset is released, the block captures four frequency-select levels and one mode level, then holds them until the next reset. The captured mode level decides the role of one shared pad:

- It can drive a gated reference clock.
- It can act as an active-low input that stops the CPU clocks.

The gating is asymmetric. The active-low power-down input and the stop request force the true CPU output low. They release the complement CPU output to high impedance. Power-down also forces every other clock low. Both control inputs pass through a two-flop synchronizer. Each gate enable may only change while its own phase is low, so no shortened pulse reaches a pad.

Top module: `clk_gate_ctrl`

## Requirements
- R1: On the first rising `clk` edge with `rst_n` high, `fs_sel` and `mode_sel` take the levels on `fs_pad_in` and `mode_pad_in`. After that they do not change until the next reset, whatever the pads do.
- R2: `strap_oe` is 0 while `rst_n` is low and until the strap capture edge, and 1 from that edge on.
- R3: With `mode_sel`=1 the shared pad is an input (`shared_oe`=0) and `stop_pad_in` low requests a CPU stop. With `mode_sel`=0, `shared_oe`=1, `shared_o` carries the gated reference phase, and `stop_pad_in` has no effect.
- R4: With `pd_n_in` low, `cpu_c_oe` is 0 and `cpu_t`, `cpu_cs`, all `pci_o`, all `sdram_o`, `usb48_o`, `dual_o`, `ref1_o` and `shared_o` are 0.
- R5: A CPU stop request drives `cpu_t` and `cpu_cs` to 0 and `cpu_c_oe` to 0, while the PCI, SDRAM, 48 MHz, dual-rate and reference outputs keep running.
- R6: `cpu_cs` equals `cpu_t` at all times.
- R7: When running, every bit of `sdram_o` equals `sdram_in`.
- R8: When running, `dual_o` follows `clk24_ph` when `rate_sel` is 1 and `usb48_ph` when it is 0. After reset it follows `usb48_ph`. The selector only switches while both phases are low.
- R9: A gate enable changes only on a `clk` edge at which its phase is low. If a phase is held high, its output keeps pulsing high after a gating request until that phase has been low at an edge. For `cpu_c_oe` the governing phase is `~cpu_ph`. A change on `pd_n_in` or `stop_pad_in` reaches the enable no earlier than the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_ph | input | 1 | CPU clock phase |
| pci_ph | input | 1 | PCI clock phase |
| ref_ph | input | 1 | Reference clock phase |
| usb48_ph | input | 1 | 48 MHz phase |
| clk24_ph | input | 1 | 24 MHz phase |
| sdram_in | input | 1 | Buffered SDRAM clock input |
| fs_pad_in | input | N_FS | Frequency-select strap levels |
| mode_pad_in | input | 1 | Mode strap level |
| stop_pad_in | input | 1 | Shared pad level, active-low CPU stop |
| pd_n_in | input | 1 | Active-low power-down |
| rate_sel | input | 1 | Configuration bit: 1 selects 24 MHz on the dual-rate output |
| fs_sel | output | N_FS | Latched frequency select |
| mode_sel | output | 1 | Latched mode |
| strap_oe | output | 1 | Driver enable of the strap-sharing pads |
| cpu_t | output | 1 | True CPU clock |
| cpu_c | output | 1 | Complement CPU clock value |
| cpu_c_oe | output | 1 | Complement CPU driver enable |
| cpu_cs | output | 1 | Chipset CPU clock |
| pci_o | output | N_PCI | PCI clocks |
| sdram_o | output | N_SDRAM | SDRAM clock copies |
| usb48_o | output | 1 | 48 MHz output |
| dual_o | output | 1 | 24/48 MHz output |
| ref1_o | output | 1 | Dedicated reference output |
| shared_o | output | 1 | Reference value for the shared pad |
| shared_oe | output | 1 | Shared pad driver enable |

## Verification
The bench resets the block once for each of the 32 strap combinations. It then toggles the pads to show that the captured values stay frozen. For both mode settings it sweeps every combination of power-down, stop and rate select, and observes the outputs with all phases high and again with all phases low:
- All-high separates forced-low outputs from running ones.
- All-low separates a tri-stated complement output from a driven one.

For the rate check, the two dual-rate source phases are set opposite, so the observed output shows which source is selected. A final run holds the PCI phase high through a power-down request, which shows that gating waits for the low phase.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

   typedef enum logic {
      RATE_48 = 1'b0,
      RATE_24 = 1'b1
   } rate_e;

   function automatic rate_e to_rate(input logic b);
      return b ? RATE_24 : RATE_48;
   endfunction

endpackage

// File: rtl/cg_sync2.sv
module cg_sync2 #(
   parameter int   W       = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   if (W < 1) begin : g_bad_w
      $error("cg_sync2: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= {W{RST_VAL}};
         q    <= {W{RST_VAL}};
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/cg_strap_latch.sv
module cg_strap_latch #(
   parameter int N_FS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_FS-1:0] fs_pad,
   input  logic            mode_pad,
   output logic [N_FS-1:0] fs_q,
   output logic            mode_q,
   output logic            done
);
   if (N_FS < 1) begin : g_bad_fs
      $error("cg_strap_latch: N_FS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= '0;
         mode_q <= 1'b0;
         done   <= 1'b0;
      end else if (!done) begin
         fs_q   <= fs_pad;
         mode_q <= mode_pad;
         done   <= 1'b1;
      end
   end

   // R1
   strap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> ($stable(fs_q) && $stable(mode_q)));
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ph,
   input  logic         run,
   output logic [W-1:0] en_q
);
   if (W < 1) begin : g_bad_w
      $error("cg_gate_cell: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      en_q[i] <= 1'b0;
         else if (!ph[i]) en_q[i] <= run;
      end

      // R9
      en_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[i] != $past(en_q[i])) |-> !$past(ph[i]));
   end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
   import clk_gate_pkg::*;
#(
   parameter int N_FS    = 4,
   parameter int N_PCI   = 6,
   parameter int N_SDRAM = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_ph,
   input  logic               pci_ph,
   input  logic               ref_ph,
   input  logic               usb48_ph,
   input  logic               clk24_ph,
   input  logic               sdram_in,
   input  logic [N_FS-1:0]    fs_pad_in,
   input  logic               mode_pad_in,
   input  logic               stop_pad_in,
   input  logic               pd_n_in,
   input  logic               rate_sel,
   output logic [N_FS-1:0]    fs_sel,
   output logic               mode_sel,
   output logic               strap_oe,
   output logic               cpu_t,
   output logic               cpu_c,
   output logic               cpu_c_oe,
   output logic               cpu_cs,
   output logic [N_PCI-1:0]   pci_o,
   output logic [N_SDRAM-1:0] sdram_o,
   output logic               usb48_o,
   output logic               dual_o,
   output logic               ref1_o,
   output logic               shared_o,
   output logic               shared_oe
);
   localparam int N_MISC = 3;

   if (N_PCI < 2) begin : g_bad_pci
      $error("clk_gate_ctrl: two PCI outputs double as straps, N_PCI >= 2");
   end
   if (N_SDRAM < 1) begin : g_bad_sd
      $error("clk_gate_ctrl: N_SDRAM must be at least 1");
   end

   logic       done;
   logic [1:0] sync_q;
   logic       pd_ok, stop_ok;
   logic       stop_req, run_all, cpu_run;
   rate_e      rate_q;
   logic       dual_ph;

   cg_strap_latch #(.N_FS(N_FS)) u_strap (
      .clk(clk), .rst_n(rst_n), .fs_pad(fs_pad_in), .mode_pad(mode_pad_in),
      .fs_q(fs_sel), .mode_q(mode_sel), .done(done));

   cg_sync2 #(.W(2), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({stop_pad_in, pd_n_in}), .q(sync_q));

   assign pd_ok    = sync_q[0];
   assign stop_ok  = sync_q[1];
   assign stop_req = mode_sel & ~stop_ok;
   assign run_all  = done & pd_ok;
   assign cpu_run  = run_all & ~stop_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rate_q <= RATE_48;
      else if (!usb48_ph && !clk24_ph) rate_q <= to_rate(rate_sel);
   end
   assign dual_ph = (rate_q == RATE_24) ? clk24_ph : usb48_ph;

   logic en_cpu, en_cpu_c, en_shr;
   logic [N_PCI-1:0]   en_pci;
   logic [N_SDRAM-1:0] en_sd;
   logic [N_MISC-1:0]  en_misc;

   cg_gate_cell #(.W(1)) u_cpu (
      .clk(clk), .rst_n(rst_n), .ph(cpu_ph), .run(cpu_run), .en_q(en_cpu));
   cg_gate_cell #(.W(1)) u_cpu_c (
      .clk(clk), .rst_n(rst_n), .ph(~cpu_ph), .run(cpu_run), .en_q(en_cpu_c));
   cg_gate_cell #(.W(N_PCI)) u_pci (
      .clk(clk), .rst_n(rst_n), .ph({N_PCI{pci_ph}}), .run(run_all), .en_q(en_pci));
   cg_gate_cell #(.W(N_SDRAM)) u_sd (
      .clk(clk), .rst_n(rst_n), .ph({N_SDRAM{sdram_in}}), .run(run_all), .en_q(en_sd));
   cg_gate_cell #(.W(N_MISC)) u_misc (
      .clk(clk), .rst_n(rst_n), .ph({ref_ph, dual_ph, usb48_ph}), .run(run_all),
      .en_q(en_misc));
   cg_gate_cell #(.W(1)) u_shr (
      .clk(clk), .rst_n(rst_n), .ph(ref_ph), .run(run_all & ~mode_sel), .en_q(en_shr));

   assign cpu_t     = cpu_ph & en_cpu;
   assign cpu_cs    = cpu_t;
   assign cpu_c     = ~cpu_ph & en_cpu_c;
   assign cpu_c_oe  = en_cpu_c;
   assign pci_o     = {N_PCI{pci_ph}} & en_pci;
   assign sdram_o   = {N_SDRAM{sdram_in}} & en_sd;
   assign usb48_o   = usb48_ph & en_misc[0];
   assign dual_o    = dual_ph & en_misc[1];
   assign ref1_o    = ref_ph & en_misc[2];
   assign shared_o  = ref_ph & en_shr;
   assign shared_oe = done & ~mode_sel;
   assign strap_oe  = done;

   // R3
   shared_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel |-> !shared_oe);
   // R4
   pd_sdram_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_ok && !sdram_in) |=> (sdram_o == '0));
   // R4
   pd_cpu_c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_ok && cpu_ph) |=> !cpu_c_oe);
   // R5
   stop_cpu_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !cpu_ph) |=> (!cpu_t && !cpu_cs));
endmodule

// File: tb/clk_gate_ctrl_test.sv
module clk_gate_ctrl_test;
   localparam int N_FS = 4, N_PCI = 6, N_SDRAM = 13;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_ph = 0, pci_ph = 0, ref_ph = 0, usb48_ph = 0, clk24_ph = 0, sdram_in = 0;
   logic [N_FS-1:0] fs_pad_in = '0;
   logic mode_pad_in = 0, stop_pad_in = 1, pd_n_in = 1, rate_sel = 0;
   logic [N_FS-1:0] fs_sel;
   logic mode_sel, strap_oe, cpu_t, cpu_c, cpu_c_oe, cpu_cs;
   logic [N_PCI-1:0] pci_o;
   logic [N_SDRAM-1:0] sdram_o;
   logic usb48_o, dual_o, ref1_o, shared_o, shared_oe;

   int vectors = 0, fails = 0;

   always #10 clk = ~clk;

   clk_gate_ctrl #(.N_FS(N_FS), .N_PCI(N_PCI), .N_SDRAM(N_SDRAM)) uut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_ph(input logic v);
      cpu_ph = v; pci_ph = v; ref_ph = v; usb48_ph = v; clk24_ph = v; sdram_in = v;
   endtask

   task automatic settle();
      @(negedge clk); set_ph(1'b0);
      repeat (4) @(negedge clk);
      set_ph(1'b1);
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset(input logic [N_FS-1:0] fs, input logic md);
      @(negedge clk);
      rst_n = 1'b0; fs_pad_in = fs; mode_pad_in = md; set_ph(1'b0);
      repeat (2) @(negedge clk);
      // R2: drivers off during reset
      check(strap_oe == 1'b0, "R2 oe in reset", 32'(strap_oe), 0);
      rst_n = 1'b1;
      #1 check(strap_oe == 1'b0, "R2 oe before capture", 32'(strap_oe), 0);
      @(negedge clk);
      check(strap_oe == 1'b1, "R2 oe after capture", 32'(strap_oe), 1);
      // R1: capture
      check({fs_sel, mode_sel} == {fs, md}, "R1 capture",
            32'({fs_sel, mode_sel}), 32'({fs, md}));
      fs_pad_in = ~fs; mode_pad_in = ~md;
      repeat (2) @(negedge clk);
      check({fs_sel, mode_sel} == {fs, md}, "R1 held",
            32'({fs_sel, mode_sel}), 32'({fs, md}));
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < 32; s++) do_reset(s[4:1], s[0]);

      for (int md = 0; md < 2; md++) begin
         do_reset('0, md[0]);
         for (int v = 0; v < 8; v++) begin
            logic pd, stp, rs, stopr, cpu;
            pd = v[0]; stp = v[1]; rs = v[2];
            pd_n_in = pd; stop_pad_in = stp; rate_sel = rs;
            settle();
            stopr = md[0] & ~stp;
            cpu   = pd & ~stopr;
            // phases high
            check(cpu_t == cpu, "R4/R5 cpu_t", 32'(cpu_t), 32'(cpu));
            check(cpu_cs == cpu_t, "R6 cpu_cs", 32'(cpu_cs), 32'(cpu_t));
            check(cpu_c_oe == cpu, "R4/R5 cpu_c_oe", 32'(cpu_c_oe), 32'(cpu));
            check(pci_o == {N_PCI{pd}}, "R4 pci", 32'(pci_o), 32'({N_PCI{pd}}));
            check(sdram_o == {N_SDRAM{pd}}, "R7 sdram high",
                  32'(sdram_o), 32'({N_SDRAM{pd}}));
            check({usb48_o, ref1_o, dual_o} == {3{pd}}, "R4 misc",
                  32'({usb48_o, ref1_o, dual_o}), 32'({3{pd}}));
            check(shared_oe == ~md[0], "R3 shared_oe", 32'(shared_oe), 32'(~md[0]));
            check(shared_o == (pd & ~md[0]), "R3 shared_o",
                  32'(shared_o), 32'(pd & ~md[0]));
            // phases low
            set_ph(1'b0);
            #1;
            check(cpu_c == cpu, "R5 cpu_c value", 32'(cpu_c), 32'(cpu));
            check({cpu_t, cpu_cs, sdram_o} == '0, "R7 sdram low",
                  32'({cpu_t, cpu_cs, sdram_o}), 0);
            // R8: opposite source phases
            usb48_ph = 1'b1;
            #1 check(dual_o == (pd & ~rs), "R8 rate 48", 32'(dual_o), 32'(pd & ~rs));
            usb48_ph = 1'b0; clk24_ph = 1'b1;
            #1 check(dual_o == (pd & rs), "R8 rate 24", 32'(dual_o), 32'(pd & rs));
            clk24_ph = 1'b0;
         end
      end

      // R9: gating waits for the low phase
      pd_n_in = 1'b1; stop_pad_in = 1'b1;
      do_reset('0, 1'b0);
      settle();
      pd_n_in = 1'b0;
      repeat (5) @(negedge clk);
      check(pci_o == {N_PCI{1'b1}}, "R9 still running while high",
            32'(pci_o), 32'({N_PCI{1'b1}}));
      pci_ph = 1'b0;
      repeat (2) @(negedge clk);
      pci_ph = 1'b1;
      #1 check(pci_o == '0, "R9 stopped after low", 32'(pci_o), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule